// File: doc/BRIEF.md
# PCM Voice Timeslot Serial Port

This block moves one companded voice sample per frame between a parallel word interface and a time-division-multiplexed PCM serial bus. The bus carries a bit clock, separate frame syncs for the two directions, a serial data input, a serial data output with an output enable, and an active-low strobe that marks the transmit timeslot. A fast system clock oversamples every bus input through a synchronizer and finds its edges. All bus timing is therefore resolved to system-clock cycles, a few cycles behind the bus edge.

Two frame-sync formats are supported. In the short format the sync is a pulse one or two bit periods wide, and it is sampled on a falling bit-clock edge. In the long format the first bit starts when both the sync and the bit clock are high. A format input chooses between them, and that choice is only taken up while both directions are idle. Holding the power-down input high for a set number of system cycles stops the port. The output then stays disabled and nothing is received until the input goes low again.

Top module: `pcm_port`

## Requirements
- R1: After reset, `dx_en` is 0, `tsx_n` is 1, `dx` is 0 and `rx_valid` is 0.
- R2: Short format: a falling bit-clock edge with `fsx` high starts a transmit slot. The W bits of the latched word then appear on `dx`, most significant bit first, one per following rising bit-clock edge.
- R3: Long format: the first transmit bit (MSB) is driven once `fsx` and `bclk` are both high after `fsx` has been low. This holds whichever of the two rose last. The remaining bits follow on later rising edges.
- R4: While `dx_en` stays high, `dx` changes only after a rising bit-clock edge.
- R5: `tsx_n` is low exactly while `dx_en` is high. Both stay active through the falling edge that ends the W-th bit and are released a few system cycles after it.
- R6: Receive captures `dr` on W falling bit-clock edges, MSB first. In short format capture starts with the falling edge after the one that sampled `fsr` high. In long format it starts with the first falling edge after `fsr` and `bclk` are both high.
- R7: Each received word appears on `rx_word` together with a `rx_valid` pulse exactly one system cycle long.
- R8: `tx_word` is latched at the start of each slot. A change during shifting does not alter the bits being sent.
- R9: `long_mode` (1 = long format, 0 = short format) is taken up only while neither direction is inside a slot. Changing it mid-slot leaves the slot in progress intact.
- R10: When `mclkr_pd` has been high for PD_HOLD consecutive system cycles, the port powers down. In that state `dx_en` is 0, `tsx_n` is 1, no slot starts and no `rx_valid` occurs. Normal operation resumes after `mclkr_pd` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bus bit clock |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| dr | input | 1 | Serial receive data |
| mclkr_pd | input | 1 | Power-down request when held high |
| long_mode | input | 1 | 1 selects long frame-sync format |
| tx_word | input | W | Parallel sample to transmit |
| dx | output | 1 | Serial transmit data, valid when dx_en is high |
| dx_en | output | 1 | Output-enable for dx; 0 means high impedance |
| tsx_n | output | 1 | Active-low transmit timeslot strobe |
| rx_word | output | W | Last received sample |
| rx_valid | output | 1 | One-cycle pulse marking a new rx_word |

## Verification
The bench builds the port with W = 8 and two synchronizer stages, and lowers PD_HOLD to 32. The small PD_HOLD lets the power-down entry, the quiet frame that follows it and the recovery fit in a short run. The bit clock runs at ten system cycles per half period. This spacing lets the late-sync long-format case start the slot in the middle of a bit-clock high phase while the first bit is still sampled before the falling edge. It also leaves room to check data stability within each bit.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

   typedef enum logic {
      FS_SHORT = 1'b0,
      FS_LONG  = 1'b1
   } fs_fmt_e;

   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
   import pcm_port_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t ev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pcm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din};
   end

   assign ev.level = pipe[STAGES-1];
   assign ev.rise  = pipe[STAGES-1] & ~pipe[STAGES];
   assign ev.fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/pcm_pd_detect.sv
module pcm_pd_detect #(
   parameter int HOLD = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pd
);
   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("pcm_pd_detect: HOLD must be positive");
      end
   endgenerate

   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LIM = CW'(HOLD);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         pd  <= 1'b0;
      end else if (!lvl) begin
         cnt <= '0;
         pd  <= 1'b0;
      end else if (cnt == LIM) begin
         pd  <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r10_pd_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      pd |-> $past(lvl));
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
   import pcm_port_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  edge_t        bck,
   input  edge_t        fs,
   input  fs_fmt_e      fmt,
   input  logic         abort,
   input  logic [W-1:0] word,
   output logic         dx,
   output logic         dx_en,
   output logic         busy
);
   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] LAST = CW'(W);

   typedef enum logic [1:0] {T_IDLE, T_PEND, T_SHIFT} tx_st_e;

   tx_st_e        st;
   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          armed;
   logic          en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= T_IDLE;
         sh    <= '0;
         cnt   <= '0;
         armed <= 1'b0;
         en    <= 1'b0;
      end else if (abort) begin
         st    <= T_IDLE;
         armed <= 1'b0;
         en    <= 1'b0;
      end else begin
         case (st)
            T_IDLE: begin
               if (!fs.level) armed <= 1'b1;
               if (fmt == FS_SHORT) begin
                  if (bck.fall && fs.level) begin
                     sh <= word;
                     st <= T_PEND;
                  end
               end else if (armed && fs.level && bck.level) begin
                  sh    <= word;
                  en    <= 1'b1;
                  cnt   <= CW'(1);
                  armed <= 1'b0;
                  st    <= T_SHIFT;
               end
            end
            T_PEND: begin
               if (bck.rise) begin
                  en  <= 1'b1;
                  cnt <= CW'(1);
                  st  <= T_SHIFT;
               end
            end
            T_SHIFT: begin
               if (bck.rise && cnt != LAST) begin
                  sh  <= {sh[W-2:0], 1'b0};
                  cnt <= cnt + 1'b1;
               end else if (bck.fall && cnt == LAST) begin
                  en <= 1'b0;
                  st <= T_IDLE;
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   assign dx    = en & sh[W-1];
   assign dx_en = en;
   assign busy  = (st != T_IDLE);

   a_r4_dx_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (dx_en && $past(dx_en) && !$past(bck.rise) && !$past(abort)) |-> $stable(dx));

   a_r5_release_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dx_en) |-> ($past(bck.fall) || $past(abort)));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
   import pcm_port_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  edge_t        bck,
   input  edge_t        fs,
   input  edge_t        din,
   input  fs_fmt_e      fmt,
   input  logic         abort,
   output logic [W-1:0] word,
   output logic         valid,
   output logic         busy
);
   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] LASTI = CW'(W - 1);

   typedef enum logic {R_IDLE, R_CAPT} rx_st_e;

   rx_st_e        st;
   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= R_IDLE;
         sh    <= '0;
         cnt   <= '0;
         armed <= 1'b0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (abort) begin
            st    <= R_IDLE;
            armed <= 1'b0;
         end else begin
            case (st)
               R_IDLE: begin
                  if (!fs.level) armed <= 1'b1;
                  if (fmt == FS_SHORT) begin
                     if (bck.fall && fs.level) begin
                        cnt <= '0;
                        st  <= R_CAPT;
                     end
                  end else if (armed && fs.level && bck.level) begin
                     cnt   <= '0;
                     armed <= 1'b0;
                     st    <= R_CAPT;
                  end
               end
               R_CAPT: begin
                  if (bck.fall) begin
                     sh  <= {sh[W-2:0], din.level};
                     cnt <= cnt + 1'b1;
                     if (cnt == LASTI) begin
                        word  <= {sh[W-2:0], din.level};
                        valid <= 1'b1;
                        st    <= R_IDLE;
                     end
                  end
               end
               default: st <= R_IDLE;
            endcase
         end
      end
   end

   assign busy = (st != R_IDLE);

   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   a_r6_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(bck.fall));
endmodule

// File: rtl/pcm_port.sv
module pcm_port
   import pcm_port_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PD_HOLD     = 4096
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bclk,
   input  logic         fsx,
   input  logic         fsr,
   input  logic         dr,
   input  logic         mclkr_pd,
   input  logic         long_mode,
   input  logic [W-1:0] tx_word,
   output logic         dx,
   output logic         dx_en,
   output logic         tsx_n,
   output logic [W-1:0] rx_word,
   output logic         rx_valid
);
   generate
      if (W < 2) begin : g_bad_width
         $error("pcm_port: W must be at least 2");
      end
   endgenerate

   localparam int NSIG   = 5;
   localparam int S_BCLK = 0;
   localparam int S_FSX  = 1;
   localparam int S_FSR  = 2;
   localparam int S_DR   = 3;
   localparam int S_PD   = 4;

   logic [NSIG-1:0] raw;
   edge_t           ev [NSIG];

   assign raw = {mclkr_pd, dr, fsr, fsx, bclk};

   generate
      for (genvar g = 0; g < NSIG; g++) begin : g_sync
         pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .ev   (ev[g])
         );
      end
   endgenerate

   logic    pd;
   logic    tx_busy, rx_busy;
   fs_fmt_e mode_q;

   pcm_pd_detect #(.HOLD(PD_HOLD)) u_pd (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (ev[S_PD].level),
      .pd   (pd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mode_q <= FS_SHORT;
      else if (!tx_busy && !rx_busy) mode_q <= long_mode ? FS_LONG : FS_SHORT;
   end

   pcm_tx #(.W(W)) u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .bck  (ev[S_BCLK]),
      .fs   (ev[S_FSX]),
      .fmt  (mode_q),
      .abort(pd),
      .word (tx_word),
      .dx   (dx),
      .dx_en(dx_en),
      .busy (tx_busy)
   );

   pcm_rx #(.W(W)) u_rx (
      .clk  (clk),
      .rst_n(rst_n),
      .bck  (ev[S_BCLK]),
      .fs   (ev[S_FSR]),
      .din  (ev[S_DR]),
      .fmt  (mode_q),
      .abort(pd),
      .word (rx_word),
      .valid(rx_valid),
      .busy (rx_busy)
   );

   assign tsx_n = ~dx_en;

   a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pd |=> (!dx_en && !rx_valid));

   a_r9_mode_held_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tx_busy) && tx_busy) |-> $stable(mode_q));
endmodule

// File: tb/sim_pcm_port.sv
module sim_pcm_port;
   localparam int W  = 8;
   localparam int PD = 32;
   localparam int HB = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk_tb = 1'b0, fsx = 1'b0, fsr = 1'b0, dr = 1'b0;
   logic pdn = 1'b0, long_mode = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic dx, dx_en, tsx_n, rx_valid;
   logic [W-1:0] rx_word;

   int checks = 0;
   int fails  = 0;
   int pd_viol = 0;
   bit in_pd = 1'b0;
   bit done = 1'b0;
   string tx_req = "R2";
   string rx_req = "R6";
   logic [W-1:0] txq[$];
   logic [W-1:0] rxq[$];
   logic [W-1:0] acc = '0;
   int nb = 0;
   bit prev_v = 1'b0;

   always #4 clk = ~clk;

   pcm_port #(.W(W), .SYNC_STAGES(2), .PD_HOLD(PD)) u0 (
      .clk(clk), .rst_n(rst_n), .bclk(bclk_tb), .fsx(fsx), .fsr(fsr), .dr(dr),
      .mclkr_pd(pdn), .long_mode(long_mode), .tx_word(tx_word),
      .dx(dx), .dx_en(dx_en), .tsx_n(tsx_n), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // transmit monitor: collects bits at each falling bit-clock edge inside the slot
   always @(negedge bclk_tb) begin
      if (in_pd) begin
         if (!tsx_n || dx_en) pd_viol++;
      end else if (!tsx_n) begin
         chk(dx_en === 1'b1, "R5 strobe and enable together", {31'd0, dx_en}, 32'd1);
         acc = {acc[W-2:0], dx};
         nb++;
         if (nb == W) begin
            nb = 0;
            if (txq.size() == 0) chk(1'b0, {tx_req, " unexpected tx slot"}, {24'd0, acc}, 32'd0);
            else begin
               logic [W-1:0] e;
               e = txq.pop_front();
               chk(acc == e, {tx_req, " tx word"}, {24'd0, acc}, {24'd0, e});
            end
         end
      end
   end

   // receive monitor
   always @(negedge clk) begin
      if (rx_valid) begin
         chk(!prev_v, "R7 valid one cycle", 32'd1, 32'd0);
         if (in_pd) pd_viol++;
         else if (rxq.size() == 0) chk(1'b0, {rx_req, " unexpected rx word"}, {24'd0, rx_word}, 32'd0);
         else begin
            logic [W-1:0] e;
            e = rxq.pop_front();
            chk(rx_word == e, {rx_req, " rx word"}, {24'd0, rx_word}, {24'd0, e});
         end
      end
      prev_v = rx_valid;
   end

   // kind 0 = short, 1 = long with sync before clock rise, 2 = long with sync after clock rise
   task automatic frame(input logic [W-1:0] tx, input logic [W-1:0] rx, input int kind,
                        input bit chg_tx, input bit chg_mode);
      logic mid;
      tx_word = tx;
      if (!in_pd) begin
         txq.push_back(tx);
         rxq.push_back(rx);
      end
      if (kind == 0) begin
         bclk_tb = 1'b1; tick(HB / 2);
         fsx = 1'b1; fsr = 1'b1; tick(HB / 2);
         bclk_tb = 1'b0; tick(HB);
      end else if (kind == 1) begin
         fsx = 1'b1; fsr = 1'b1; tick(HB);
      end
      for (int i = W - 1; i >= 0; i--) begin
         bclk_tb = 1'b1;
         dr = rx[i];
         tick(HB / 2);
         if (i == W - 1) begin
            if (kind == 0) begin fsx = 1'b0; fsr = 1'b0; end
            if (kind == 2) begin fsx = 1'b1; fsr = 1'b1; end
            if (chg_tx) tx_word = ~tx;
            if (chg_mode) long_mode = ~long_mode;
         end
         tick(HB / 2 - 1);
         mid = dx;
         tick(1);
         if (!in_pd && !(kind == 2 && i == W - 1))
            chk(dx === mid, "R4 dx stable within bit", {31'd0, dx}, {31'd0, mid});
         bclk_tb = 1'b0;
         tick(HB);
      end
      fsx = 1'b0; fsr = 1'b0;
      chk(dx_en == 1'b0 && tsx_n == 1'b1, "R5 released after last bit", {30'd0, dx_en, tsx_n}, 32'd1);
      if (chg_mode) long_mode = ~long_mode;
      tick(2 * HB);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      tick(5);
      chk(dx_en == 1'b0 && tsx_n == 1'b1 && dx == 1'b0 && rx_valid == 1'b0,
          "R1 reset outputs", {29'd0, dx_en, tsx_n, dx, rx_valid}, 32'h4);
      rst_n = 1'b1;
      tick(5);
      chk(dx_en == 1'b0 && tsx_n == 1'b1, "R1 idle after reset", {30'd0, dx_en, tsx_n}, 32'd1);

      tx_req = "R2 short"; rx_req = "R6 short";
      frame(8'hA5, 8'h3C, 0, 1'b0, 1'b0);
      frame(8'h00, 8'hFF, 0, 1'b0, 1'b0);
      frame(8'hFF, 8'h01, 0, 1'b0, 1'b0);

      long_mode = 1'b1; tick(4);
      tx_req = "R3 long sync first"; rx_req = "R6 long";
      frame(8'h81, 8'h7E, 1, 1'b0, 1'b0);
      tx_req = "R3 long clock first";
      frame(8'h5A, 8'hC3, 2, 1'b0, 1'b0);
      tx_req = "R3 long";
      frame(8'h96, 8'h69, 1, 1'b0, 1'b0);
      long_mode = 1'b0; tick(4);

      tx_req = "R8 latched word"; rx_req = "R8 rx alongside";
      frame(8'h4D, 8'hB2, 0, 1'b1, 1'b0);
      tx_req = "R9 mode change mid-slot"; rx_req = "R9 mode change mid-slot";
      frame(8'h2E, 8'hD1, 0, 1'b0, 1'b1);

      pdn = 1'b1;
      tick(PD + 8);
      chk(dx_en == 1'b0 && tsx_n == 1'b1, "R10 power-down outputs", {30'd0, dx_en, tsx_n}, 32'd1);
      in_pd = 1'b1;
      frame(8'hC6, 8'h39, 0, 1'b0, 1'b0);
      in_pd = 1'b0;
      chk(pd_viol == 0, "R10 no slot during power-down", pd_viol, 32'd0);
      pdn = 1'b0;
      tick(8);
      tx_req = "R10 resume"; rx_req = "R10 resume";
      frame(8'hE7, 8'h18, 0, 1'b0, 1'b0);

      tick(10);
      chk(txq.size() == 0, "R2 every tx slot produced", txq.size(), 32'd0);
      chk(rxq.size() == 0, "R7 every rx word presented", rxq.size(), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule